// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a shift register of the most recent resolved branch outcomes, the global history. It also keeps a direct-mapped table of saturating counters. The table is addressed by a branch's word-aligned address bits placed above the history bits. Each static branch therefore owns one counter for every possible recent-outcome pattern. Entries carry no tag. Two branches whose low address bits match share counters, so a counter is only a hint.

The fetch stage presents an address on the lookup port. It receives a combinational taken / not-taken answer and the current global history, which it keeps with the branch. When the branch resolves, the back end returns the address, the real outcome and that saved history snapshot on the update port. At most one update arrives per cycle, in program order. The block rebuilds the index from the snapshot, trains the counter it selects, and shifts the outcome into the global history. Setting the history length to zero gives a plain per-address counter table. A counter width of one gives a last-outcome bit.

Top module: `corr_bp`

## Requirements
- R1: Reset clears the global history to zero. Each update shifts the history left by one place and puts the outcome in bit 0 (1 = taken). A cycle without an update leaves the history unchanged. The current history is always visible on `lkp_hist_o`.
- R2: The table index is {address[IDX_W+1:2], history}, with the history in the low bits. Address bits 1:0 and the bits above IDX_W+1 play no part in the index. A lookup uses the live history. An update uses `upd_hist_i`, whatever the live history is.
- R3: Each entry is a CTR_W-bit saturating counter. A taken update adds one, up to 2^CTR_W−1. A not-taken update subtracts one, down to 0.
- R4: The prediction is taken exactly when the selected counter is at least 2^(CTR_W−1).
- R5: After reset every counter holds 2^(CTR_W−1)−1 (01 for two-bit counters, 0 for one-bit counters). Every lookup then predicts not-taken.
- R6: A lookup that selects the entry being updated in the same cycle returns the value from before the update. The new value shows on the next cycle.
- R7: Entries are untagged. Addresses that differ only in bits outside the index field read and train the same counter.
- R8: With HIST_W = 0 the index is the address field alone, and `lkp_hist_o` reads 0. With CTR_W = 1 each entry holds the last outcome written to it, so a misprediction inverts it.
- R9: While `upd_valid_i` is low, no counter changes and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_pc_i | input | ADDR_W | Address of the branch being predicted |
| lkp_taken_o | output | 1 | Prediction, 1 = taken |
| lkp_hist_o | output | max(HIST_W,1) | Current global history, kept by the caller as a snapshot |
| upd_valid_i | input | 1 | A resolved branch is presented this cycle |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |
| upd_hist_i | input | max(HIST_W,1) | History snapshot taken when this branch was predicted |

## Verification
The bench builds two instances and drives both with the same stimulus. The first is a (2,2) predictor with a 4-bit address field, small enough to drive each of the 64 counters to both saturation limits. It also covers stale snapshots against live history and aliasing through high and low address bits. The second uses no history and one-bit counters with a 3-bit field. It covers the degenerate configuration, where history plays no part and a single misprediction flips an entry.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned CTR_W_MAX = 8;

  function automatic logic [CTR_W_MAX-1:0] ctr_step(
    input logic [CTR_W_MAX-1:0] cur,
    input logic [CTR_W_MAX-1:0] maxv,
    input logic                 up
  );
    if (up) return (cur == maxv) ? cur : cur + 8'd1;
    else    return (cur == '0)   ? cur : cur - 8'd1;
  endfunction
endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int unsigned HIST_W = 2,
  localparam int unsigned HW_P  = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            bit_i,
  output logic [HW_P-1:0] hist_o
);
  if (HIST_W == 0) begin : g_none
    logic ghr_unused;
    assign ghr_unused = ^{clk_i, rst_ni, shift_i, bit_i};
    assign hist_o = '0;
  end else if (HIST_W == 1) begin : g_one
    logic hist_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist_q <= 1'b0;
      else if (shift_i) hist_q <= bit_i;
    end
    assign hist_o = hist_q;
  end else begin : g_multi
    logic [HIST_W-1:0] hist_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist_q <= '0;
      else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], bit_i};
    end
    assign hist_o = hist_q;
  end
endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned HIST_W = 2,
  localparam int unsigned HW_P   = (HIST_W > 0) ? HIST_W : 1,
  localparam int unsigned TIDX_W = IDX_W + HIST_W
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [HW_P-1:0]   hist_i,
  output logic [TIDX_W-1:0] idx_o
);
  // word-aligned fetch: bits 1:0 never distinguish branches
  logic pc_unused;
  assign pc_unused = ^{pc_i[ADDR_W-1:IDX_W+2], pc_i[1:0]};

  if (HIST_W == 0) begin : g_addr_only
    logic hist_unused;
    assign hist_unused = ^hist_i;
    assign idx_o = pc_i[IDX_W+1:2];
  end else begin : g_concat
    assign idx_o = {pc_i[IDX_W+1:2], hist_i};
  end
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int unsigned TIDX_W = 10,
  parameter int unsigned CTR_W  = 2,
  localparam int unsigned DEPTH = 1 << TIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIDX_W-1:0] rd_idx_i,
  output logic [CTR_W-1:0]  rd_ctr_o,
  input  logic              wr_en_i,
  input  logic [TIDX_W-1:0] wr_idx_i,
  input  logic              wr_taken_i
);
  localparam logic [CTR_W-1:0] RST_VAL = CTR_W'((1 << (CTR_W - 1)) - 1);
  localparam logic [CTR_W-1:0] MAX_VAL = '1;

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [CTR_W-1:0] wr_old;
  logic [CTR_W-1:0] wr_new;

  assign rd_ctr_o = ctr_q[rd_idx_i];
  assign wr_old   = ctr_q[wr_idx_i];

  if (CTR_W == 1) begin : g_last_outcome
    // entry follows the outcome; a mispredict flips it
    logic old_unused;
    assign old_unused = ^wr_old;
    assign wr_new = wr_taken_i;
  end else begin : g_saturate
    logic [bp_pkg::CTR_W_MAX-1:0] nxt_wide_unused;
    assign nxt_wide_unused = bp_pkg::ctr_step(bp_pkg::CTR_W_MAX'(wr_old),
                                              bp_pkg::CTR_W_MAX'(MAX_VAL),
                                              wr_taken_i);
    assign wr_new = nxt_wide_unused[CTR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= RST_VAL;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= wr_new;
    end
  end
endmodule

// File: rtl/corr_bp.sv
module corr_bp #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned HIST_W = 2,
  parameter int unsigned CTR_W  = 2,
  localparam int unsigned HW_P   = (HIST_W > 0) ? HIST_W : 1,
  localparam int unsigned TIDX_W = IDX_W + HIST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lkp_pc_i,
  output logic              lkp_taken_o,
  output logic [HW_P-1:0]   lkp_hist_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [HW_P-1:0]   upd_hist_i
);
  logic [TIDX_W-1:0] lkp_idx;
  logic [TIDX_W-1:0] upd_idx;
  logic [CTR_W-1:0]  lkp_ctr;

  bp_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (upd_valid_i),
    .bit_i   (upd_taken_i),
    .hist_o  (lkp_hist_o)
  );

  bp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_lkp_idx (
    .pc_i   (lkp_pc_i),
    .hist_i (lkp_hist_o),
    .idx_o  (lkp_idx)
  );

  // update rebuilds its index from the snapshot, not the live history
  bp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_upd_idx (
    .pc_i   (upd_pc_i),
    .hist_i (upd_hist_i),
    .idx_o  (upd_idx)
  );

  bp_ctr_table #(.TIDX_W(TIDX_W), .CTR_W(CTR_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lkp_idx),
    .rd_ctr_o   (lkp_ctr),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (upd_idx),
    .wr_taken_i (upd_taken_i)
  );

  assign lkp_taken_o = lkp_ctr[CTR_W-1];
endmodule

// File: rtl/corr_bp_chk.sv
module corr_bp_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned HIST_W = 2,
  parameter int unsigned CTR_W  = 2,
  localparam int unsigned HW_P   = (HIST_W > 0) ? HIST_W : 1,
  localparam int unsigned TIDX_W = IDX_W + HIST_W,
  localparam int unsigned DEPTH  = 1 << TIDX_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] lkp_pc_i,
  input logic              lkp_taken_o,
  input logic [HW_P-1:0]   lkp_hist_o,
  input logic              upd_valid_i,
  input logic              upd_taken_i,
  input logic [TIDX_W-1:0] upd_idx_i,
  input logic [CTR_W-1:0]  ctr_i [DEPTH]
);
  localparam logic [CTR_W-1:0] MAXV = '1;

  function automatic logic [CTR_W-1:0] up1(input logic [CTR_W-1:0] c);
    return (c == MAXV) ? MAXV : c + CTR_W'(1);
  endfunction
  function automatic logic [CTR_W-1:0] dn1(input logic [CTR_W-1:0] c);
    return (c == '0) ? '0 : c - CTR_W'(1);
  endfunction

  // R3: taken outcome saturates upward
  a_r3_inc_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_taken_i |=> ctr_i[$past(upd_idx_i)] == up1($past(ctr_i[upd_idx_i])));

  // R3: not-taken outcome saturates downward
  a_r3_dec_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !upd_taken_i |=> ctr_i[$past(upd_idx_i)] == dn1($past(ctr_i[upd_idx_i])));

  // R9: no update keeps history
  a_r9_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(lkp_hist_o));

  // R9: no update, same address -> same prediction
  a_r9_pred_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> (lkp_pc_i != $past(lkp_pc_i)) || (lkp_taken_o == $past(lkp_taken_o)));

  if (HIST_W > 0) begin : g_hist_chk
    // R1: newest outcome lands in bit 0
    a_r1_hist_newest: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_valid_i |=> lkp_hist_o[0] == $past(upd_taken_i));
  end else begin : g_nohist_chk
    // R8: history reads zero without history bits
    a_r8_hist_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lkp_hist_o == '0);
  end
endmodule

bind corr_bp corr_bp_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .CTR_W(CTR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lkp_pc_i    (lkp_pc_i),
  .lkp_taken_o (lkp_taken_o),
  .lkp_hist_o  (lkp_hist_o),
  .upd_valid_i (upd_valid_i),
  .upd_taken_i (upd_taken_i),
  .upd_idx_i   (upd_idx),
  .ctr_i       (u_tbl.ctr_q)
);

// File: tb/tb_corr_bp.sv
module tb_corr_bp;
  localparam int AW = 16;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [AW-1:0] lkp_pc = '0, upd_pc = '0;
  logic          upd_v = 0, upd_t = 0;
  logic [1:0]    upd_h = '0;
  logic          pred_a, pred_b;
  logic [1:0]    hist_a;
  logic          hist_b;

  corr_bp #(.ADDR_W(AW), .IDX_W(4), .HIST_W(2), .CTR_W(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lkp_pc_i(lkp_pc), .lkp_taken_o(pred_a),
    .lkp_hist_o(hist_a), .upd_valid_i(upd_v), .upd_pc_i(upd_pc),
    .upd_taken_i(upd_t), .upd_hist_i(upd_h));

  corr_bp #(.ADDR_W(AW), .IDX_W(3), .HIST_W(0), .CTR_W(1)) dut_m0 (
    .clk_i(clk), .rst_ni(rst_n), .lkp_pc_i(lkp_pc), .lkp_taken_o(pred_b),
    .lkp_hist_o(hist_b), .upd_valid_i(upd_v), .upd_pc_i(upd_pc),
    .upd_taken_i(upd_t), .upd_hist_i(1'b0));

  int n_chk = 0, n_fail = 0;
  int ma [64];
  int mb [8];
  int ha = 0;

  function automatic int ia(input int pc, input int h);
    return (((pc >> 2) & 15) << 2) | (h & 3);
  endfunction
  function automatic int ib(input int pc);
    return (pc >> 2) & 7;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (ma[i]) ma[i] = 1;
    foreach (mb[i]) mb[i] = 0;
    ha = 0;
  endtask

  task automatic step(input int pc, input bit v, input int upc, input bit t,
                      input int uh, input string tag);
    int ea, eb;
    @(negedge clk);
    lkp_pc = AW'(pc); upd_v = v; upd_pc = AW'(upc); upd_t = t; upd_h = 2'(uh);
    #1;
    ea = (ma[ia(pc, ha)] >= 2) ? 1 : 0;
    eb = mb[ib(pc)];
    chk(pred_a == ea, tag, int'(pred_a), ea);
    chk(hist_a == 2'(ha), "R1", int'(hist_a), ha);
    chk(pred_b == eb, "R8", int'(pred_b), eb);
    chk(hist_b == 1'b0, "R8", int'(hist_b), 0);
    @(posedge clk);
    if (v && rst_n) begin
      int k = ia(upc, uh);
      if (t) ma[k] = (ma[k] == 3) ? 3 : ma[k] + 1;
      else   ma[k] = (ma[k] == 0) ? 0 : ma[k] - 1;
      mb[ib(upc)] = t;
      ha = ((ha << 1) | int'(t)) & 3;
    end
  endtask

  task automatic run(input int pc, input bit t, input string tag);
    step(pc, 1, pc, t, ha, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    // R5: reset state, all counters weakly not-taken, history zero
    for (int p = 0; p < 64; p += 4) step(p, 0, 0, 0, 0, "R5");
    @(negedge clk); rst_n = 1;
    for (int p = 0; p < 64; p += 4) step(p, 0, 0, 0, 0, "R5");

    // R3/R4: loop branch, 9 taken then 1 not-taken, repeated
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 10; i++) run(16'h0040, (i != 9), "R4");

    // R3: upper saturation with fixed snapshot, then lower saturation
    for (int i = 0; i < 6; i++) step(16'h0024, 1, 16'h0024, 1, 2, "R3");
    for (int i = 0; i < 6; i++) step(16'h0024, 1, 16'h0024, 0, 2, "R3");

    // R6: lookup and update hit the same entry every cycle
    for (int i = 0; i < 8; i++) run(16'h0010, (i % 3 != 0), "R6");

    // R2: update index from stale snapshot, not live history
    for (int i = 0; i < 4; i++) step(16'h0034, 1, 16'h0034, 1, 1, "R2");
    for (int h = 0; h < 4; h++) step(16'h0034, 1, 16'h0008, h[0], h, "R2");

    // R7: aliasing through bits outside the index field
    for (int i = 0; i < 5; i++) run(16'h0104 | (i & 3), 1, "R7");
    for (int i = 0; i < 5; i++) run(16'hF004 | (i & 3), 0, "R7");

    // R9: idle cycles change nothing
    for (int i = 0; i < 10; i++) step(i * 4, 0, 16'h0030, 1, 3, "R9");

    // R8: last-outcome bit flips on each mispredict
    for (int i = 0; i < 12; i++) run(16'h001C, i[1], "R8");

    // mixed pattern sweep
    for (int i = 0; i < 300; i++) run((i * 36) & 16'h00FC, ((i * 7) % 5) < 3, "R4");

    finish_run();
  end
endmodule